// File: doc/BRIEF.md
# Accumulator ALU With Status Flags

This block is the arithmetic and logic core behind the accumulator of a small 8-bit processor. Each cycle it takes an operation code, the present accumulator value, a memory operand and the present status byte. In the same cycle it produces the operation's result and a write-enable for the accumulator. The flags that the operation leaves behind are held in a status register and appear one clock later.

The operations are binary add with the carry flag as carry-in, bitwise AND, OR and XOR, shift left, shift right, rotate left, rotate right through carry, and a bit test. The bit test changes only flags and never writes the accumulator. A cycle with the valid strobe low leaves the status register untouched. A valid cycle with a code outside the defined set copies the incoming status byte and does not write.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `status_q` becomes 8'h20. Only the always-one bit 5 is set.
- R2: Code 4'h0 (add) gives `result` = (acc + operand + C) mod 256. The new C (bit 0) is 1 exactly when that sum exceeds 255.
- R3: For code 4'h0, the new V (bit 6) is 1 exactly when acc and operand have equal bit 7 and the result's bit 7 differs from it.
- R4: For every operation that writes, the new N (bit 7) equals result bit 7 and the new Z (bit 1) is 1 exactly when the result is zero.
- R5: Codes 4'h1 (AND), 4'h2 (OR) and 4'h3 (XOR) write the bitwise combination of acc and operand. They keep C and V from `status_in`.
- R6: Code 4'h4 shifts acc left, filling bit 0 with 0, and moves old bit 7 into C. Code 4'h5 shifts right, filling bit 7 with 0, and moves old bit 0 into C, so N becomes 0. Both keep V.
- R7: Code 4'h6 rotates left with the old C entering bit 0. Code 4'h7 rotates right with the old C entering bit 7. Each moves the bit pushed out into C.
- R8: Code 4'h8 (bit test) drives `result_we` low and `result` equal to `acc_in`. It sets Z when (acc AND operand) is zero, copies operand bit 7 to N and operand bit 6 to V, and keeps C.
- R9: On every valid cycle, bits 4, 3 and 2 of `status_q` take their values from `status_in`. Bit 5 of `status_q` is always 1.
- R10: With `op_valid` low, `result_we` is 0 and `status_q` holds its value. A valid code from 4'h9 to 4'hF does not write, and it loads `status_in` with bit 5 forced to 1.
- R11: `result` and `result_we` follow the inputs in the same cycle. `status_q` shows the flags of a valid operation after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe for this cycle |
| op_code | input | 4 | Operation select |
| acc_in | input | 8 | Present accumulator value |
| opnd_in | input | 8 | Memory operand |
| status_in | input | 8 | Present status byte (N,V,1,B,D,I,Z,C from bit 7 down) |
| result | output | 8 | Combinational operation result |
| result_we | output | 1 | Accumulator write-enable |
| status_q | output | 8 | Registered status byte after the last valid operation |

## Verification
The assertions assume that `op_code`, `acc_in`, `opnd_in` and `status_in` are stable between falling and rising edges. They also assume that `status_in` is whatever the surrounding processor supplies, which need not match `status_q`. The stimulus changes the inputs only at falling edges and draws `status_in` independently of `status_q`, so no property depends on feedback between them. Random cycles cover all sixteen codes, including the unused ones, and drop the valid strobe at random.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    parameter int ALU_W = 8;
    localparam int MSB = ALU_W - 1;

    // status byte positions (decoded by the surrounding processor)
    localparam int SB_N   = 7;
    localparam int SB_V   = 6;
    localparam int SB_ONE = 5;
    localparam int SB_B   = 4;
    localparam int SB_D   = 3;
    localparam int SB_I   = 2;
    localparam int SB_Z   = 1;
    localparam int SB_C   = 0;
    localparam logic [7:0] STATUS_RST = 8'h20;

    typedef enum logic [3:0] {
        OP_ADD = 4'h0,
        OP_AND = 4'h1,
        OP_OR  = 4'h2,
        OP_XOR = 4'h3,
        OP_SHL = 4'h4,
        OP_SHR = 4'h5,
        OP_ROL = 4'h6,
        OP_ROR = 4'h7,
        OP_TST = 4'h8
    } alu_op_e;

    // per-unit outcome: value, write, and each flag with its own update enable
    typedef struct packed {
        logic [ALU_W-1:0] val;
        logic             wr;
        logic             c;
        logic             c_en;
        logic             v;
        logic             v_en;
        logic             n;
        logic             n_en;
        logic             z;
        logic             z_en;
    } unit_out_t;

    function automatic unit_out_t unit_none();
        unit_out_t u;
        u = '0;
        return u;
    endfunction

    function automatic unit_out_t with_nz(unit_out_t u);
        unit_out_t r;
        r      = u;
        r.n    = u.val[MSB];
        r.n_en = 1'b1;
        r.z    = (u.val == '0);
        r.z_en = 1'b1;
        r.wr   = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder
    import acc_alu_pkg::*;
(
    input  logic [ALU_W-1:0] a,
    input  logic [ALU_W-1:0] m,
    input  logic             cin,
    output unit_out_t        o
);
    logic [ALU_W:0] sum;

    always_comb begin
        sum    = {1'b0, a} + {1'b0, m} + {{ALU_W{1'b0}}, cin};
        o      = unit_none();
        o.val  = sum[ALU_W-1:0];
        o.c    = sum[ALU_W];
        o.c_en = 1'b1;
        o.v    = (a[MSB] == m[MSB]) && (sum[MSB] != a[MSB]);
        o.v_en = 1'b1;
        o      = with_nz(o);
    end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
(
    input  logic [3:0]       op,
    input  logic [ALU_W-1:0] a,
    input  logic [ALU_W-1:0] m,
    output unit_out_t        o
);
    logic [ALU_W-1:0] masked;

    always_comb begin
        masked = a & m;
        o      = unit_none();
        case (op)
            OP_AND: begin o.val = masked; o = with_nz(o); end
            OP_OR:  begin o.val = a | m;  o = with_nz(o); end
            OP_XOR: begin o.val = a ^ m;  o = with_nz(o); end
            OP_TST: begin
                o.val  = a;
                o.z    = (masked == '0);
                o.z_en = 1'b1;
                o.n    = m[MSB];
                o.n_en = 1'b1;
                o.v    = m[MSB-1];
                o.v_en = 1'b1;
            end
            default: o.val = a;
        endcase
    end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
    import acc_alu_pkg::*;
(
    input  logic [1:0]       kind,   // 0 shl, 1 shr, 2 rol, 3 ror
    input  logic [ALU_W-1:0] a,
    input  logic             cin,
    output unit_out_t        o
);
    logic fill;

    always_comb begin
        fill   = kind[1] & cin;
        o      = unit_none();
        o.c_en = 1'b1;
        if (kind[0]) begin
            o.val = {fill, a[ALU_W-1:1]};
            o.c   = a[0];
        end else begin
            o.val = {a[ALU_W-2:0], fill};
            o.c   = a[MSB];
        end
        o = with_nz(o);
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       op_valid,
    input  logic [3:0] op_code,
    input  logic [7:0] acc_in,
    input  logic [7:0] opnd_in,
    input  logic [7:0] status_in,
    output logic [7:0] result,
    output logic       result_we,
    output logic [7:0] status_q
);
    unit_out_t add_o, log_o, sh_o, sel;
    logic [7:0] nxt_status;

    acc_alu_adder u_add (
        .a(acc_in), .m(opnd_in), .cin(status_in[SB_C]), .o(add_o)
    );
    acc_alu_logic u_log (
        .op(op_code), .a(acc_in), .m(opnd_in), .o(log_o)
    );
    acc_alu_shift u_sh (
        .kind(op_code[1:0]), .a(acc_in), .cin(status_in[SB_C]), .o(sh_o)
    );

    always_comb begin
        case (op_code)
            OP_ADD:                          sel = add_o;
            OP_AND, OP_OR, OP_XOR, OP_TST:   sel = log_o;
            OP_SHL, OP_SHR, OP_ROL, OP_ROR:  sel = sh_o;
            default: begin
                sel     = unit_none();
                sel.val = acc_in;
            end
        endcase
    end

    always_comb begin
        nxt_status         = status_in;
        nxt_status[SB_ONE] = 1'b1;
        if (sel.c_en) nxt_status[SB_C] = sel.c;
        if (sel.v_en) nxt_status[SB_V] = sel.v;
        if (sel.n_en) nxt_status[SB_N] = sel.n;
        if (sel.z_en) nxt_status[SB_Z] = sel.z;
    end

    assign result    = sel.wr ? sel.val : acc_in;
    assign result_we = op_valid & sel.wr;

    always_ff @(posedge clk) begin
        if (rst)           status_q <= STATUS_RST;
        else if (op_valid) status_q <= nxt_status;
    end

    AST_ONE_BIT_SET: assert property (@(posedge clk) disable iff (rst)
        status_q[SB_ONE]); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(status_q)); // R10
    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_TST) |-> (!result_we && result == acc_in)); // R8
    AST_TEST_COPIES_NV: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_TST) |=>
        (status_q[SB_N] == $past(opnd_in[7]) && status_q[SB_V] == $past(opnd_in[6]))); // R8
    AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR)) |=>
        (status_q[SB_C] == $past(status_in[SB_C]) && status_q[SB_V] == $past(status_in[SB_V]))); // R5
    AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (rst)
        (result_we && result == 8'h00) |=> status_q[SB_Z]); // R4
    AST_SHR_CLEARS_N: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_SHR) |=> !status_q[SB_N]); // R6
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       op_valid;
    logic [3:0] op_code;
    logic [7:0] acc_in, opnd_in, status_in;
    logic [7:0] result;
    logic       result_we;
    logic [7:0] status_q;

    int checks = 0;
    int errors = 0;
    int exp_st = 32'h20;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .acc_in(acc_in), .opnd_in(opnd_in), .status_in(status_in),
        .result(result), .result_we(result_we), .status_q(status_q)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input int op);
        if (op == 0) return "R2 R3 R4";
        if (op <= 3) return "R4 R5";
        if (op <= 5) return "R4 R6";
        if (op <= 7) return "R4 R7";
        if (op == 8) return "R8";
        return "R10";
    endfunction

    // behavioural reference from the requirements
    task automatic ref_calc(input int op, input int a, input int m, input int st,
                            output int res, output bit we, output int nst);
        int c, n, v, z, s;
        c = st & 1; v = (st >> 6) & 1; n = (st >> 7) & 1; z = (st >> 1) & 1;
        res = a; we = 1'b1;
        case (op)
            0: begin
                s = a + m + c; res = s & 255; c = (s > 255) ? 1 : 0;
                v = (((a ^ m) & 128) == 0 && ((a ^ res) & 128) != 0) ? 1 : 0;
            end
            1: res = a & m;
            2: res = a | m;
            3: res = a ^ m;
            4: begin res = (a << 1) & 255; c = (a >> 7) & 1; end
            5: begin res = a >> 1; c = a & 1; end
            6: begin res = ((a << 1) | c) & 255; c = (a >> 7) & 1; end
            7: begin res = (a >> 1) | (c << 7); c = a & 1; end
            8: begin
                we = 1'b0;
                z = ((a & m) == 0) ? 1 : 0; n = (m >> 7) & 1; v = (m >> 6) & 1;
            end
            default: we = 1'b0;
        endcase
        if (we) begin
            n = (res >> 7) & 1;
            z = (res == 0) ? 1 : 0;
        end
        nst = (n << 7) | (v << 6) | 32 | (st & 28) | (z << 1) | c;
    endtask

    task automatic step(input bit vld, input int op, input int a, input int m, input int st);
        int res, nst;
        bit we;
        string rq;
        @(negedge clk);
        op_valid = vld; op_code = op[3:0];
        acc_in = a[7:0]; opnd_in = m[7:0]; status_in = st[7:0];
        rq = vld ? req_of(op) : "R10";
        ref_calc(op, a, m, st, res, we, nst);
        #1;
        chk({rq, " R11 result"}, int'(result), res);
        chk({rq, " R11 we"}, int'(result_we), int'(vld & we));
        @(posedge clk);
        if (vld) exp_st = nst;
        #1;
        chk({rq, " R9 R11 status"}, int'(status_q), exp_st);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_code = '0;
        acc_in = '0; opnd_in = '0; status_in = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset status", int'(status_q), 32'h20);
        @(negedge clk);
        rst = 1'b0;

        step(1, 0, 8'h50, 8'h50, 8'h00);   // R3 signed overflow, N set
        step(1, 0, 8'hFF, 8'h01, 8'h00);   // R2 carry out, R4 zero
        step(1, 0, 8'h10, 8'h20, 8'h01);   // R2 carry in
        step(1, 0, 8'h80, 8'h80, 8'h00);   // R2 R3 carry and overflow
        step(1, 1, 8'hF0, 8'h3C, 8'h41);   // R5 keeps C and V
        step(1, 2, 8'h00, 8'h00, 8'h41);   // R5 OR, R4 zero
        step(1, 3, 8'hAA, 8'h55, 8'h00);   // R5 XOR, R4 negative
        step(1, 4, 8'h81, 8'h00, 8'h40);   // R6 shift left, V kept
        step(1, 5, 8'h01, 8'h00, 8'h80);   // R6 shift right to zero
        step(1, 6, 8'h80, 8'h00, 8'h01);   // R7 rotate left, carry in
        step(1, 7, 8'h01, 8'h00, 8'h00);   // R7 rotate right to zero
        step(1, 7, 8'h02, 8'h00, 8'h01);   // R7 carry into bit 7
        step(1, 8, 8'h0F, 8'hC0, 8'h01);   // R8 Z, N, V from operand
        step(1, 8, 8'hFF, 8'h01, 8'hC2);   // R8 nonzero mask clears N V Z
        step(1, 1, 8'hFF, 8'h0F, 8'h1C);   // R9 B D I copied
        step(0, 0, 8'h7F, 8'h7F, 8'hFF);   // R10 idle holds
        step(1, 15, 8'h12, 8'h34, 8'hC3);  // R10 unused code loads status_in

        for (int i = 0; i < 600; i++) begin
            step(($urandom % 8) != 0, int'($urandom % 16), int'($urandom % 256),
                 int'($urandom % 256), int'($urandom % 256));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule